// File: doc/BRIEF.md
# Hardware Breakpoint Comparator

This block watches a processor's instruction fetch stream and its data-space accesses. It raises a break request when either one matches a programmed breakpoint. There are five code-address comparators, each holding a full program-counter value. A fetch whose address equals an armed comparator produces a break before that instruction runs. A single data comparator checks the address and the value of each data access under per-bit don't-care masks. It can be limited to reads, to writes, or to both.

Software or a debug port programs the comparators through a small write-only register bus. Each code address can be loaded in one write, or in two writes that load its low and high parts. The break request is a registered pulse that lasts one clock for each matching cycle, and it feeds the halt logic, which lies outside this block. A sticky status bit records that a break has happened since the last stop command.

Top module: `bkpt_unit`

## Requirements
- R1: After synchronous reset, brk_req and brk_status are 0. Every code address resets to 0xFFFFFF, all enable bits reset to 0, both match registers reset to 0, and both mask registers reset to 0xFFFF.
- R2: When pc_valid is high and pc equals an armed code address, brk_req is high in the following cycle.
- R3: Code comparator 0 is always armed. Comparators 1 to 4 are armed by enable-register bits 0 to 3 respectively.
- R4: The register addresses are as follows. Addresses 0 to 4 load code address k in full from reg_wdata[23:0]. Addresses 8 to 12 load only bits [15:0] of code address k. Addresses 16 to 20 load only bits [23:16] of code address k from reg_wdata[7:0]. Address 24 loads the enable register, 25 the address match, 26 the address mask, 27 the value match and 28 the value mask, each from the low bits of reg_wdata.
- R5: A cycle with pc_valid low and dacc_valid low never produces a break.
- R6: In the data comparator, a mask bit of 1 makes the corresponding address or value bit don't-care, and a mask bit of 0 requires it to equal the match bit.
- R7: A data break needs the compared address bits and the compared value bits to match in the same access. An address match with a value mismatch gives no break.
- R8: Enable bit 5 lets reads (dacc_write=0) trigger the data comparator, and enable bit 6 lets writes (dacc_write=1) trigger it.
- R9: The data comparator fires only while enable bit 4 is set.
- R10: brk_status is set in the cycle that brk_req is raised and stays set until a stop_cmd cycle with no new match, which clears it. If a match and stop_cmd occur in the same cycle, the set wins.
- R11: brk_req is high for exactly one cycle for each matching input cycle and is low after a non-matching cycle.
- R12: A register write takes effect from the next cycle. A fetch in the same cycle as a write is compared against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 24 | Register write data |
| pc_valid | input | 1 | Fetch address is valid this cycle |
| pc | input | 24 | Address of the instruction about to execute |
| dacc_valid | input | 1 | Data access is occurring this cycle |
| dacc_write | input | 1 | 1 for a write access, 0 for a read |
| dacc_addr | input | 16 | Data access address |
| dacc_data | input | 16 | Data access value |
| stop_cmd | input | 1 | Stop command, clears break status |
| brk_req | output | 1 | Registered break request |
| brk_status | output | 1 | Sticky break-occurred flag |

## Verification
The bench covers the following corner cases, and shows what a faulty design would do in each.
- The reset value of comparator 0. A design that reset it to zero would break on the very first fetch.
- A split load of the low and high halves of a code address. Swapped halves, or a partial write that clobbers the other part, would move the break address.
- Don't-care address bits. An inverted mask sense would fire on the wrong accesses.
- A value mismatch at a matching address. A design that ORed the address and value terms would fire here.
- A match in the same cycle as a stop command. A clear that took priority over the set would lose that break.
- A write and a fetch in the same cycle. A write forwarded into the comparison would break one cycle early at the new address.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    parameter int NUM_CODE = 5;
    parameter int PC_W     = 24;
    parameter int DW       = 16;
    parameter int RA_W     = 5;
    parameter int IDX_W    = 3;
    localparam int HI_W    = PC_W - DW;

    typedef enum logic [1:0] {
        RG_FULL = 2'd0,
        RG_LO   = 2'd1,
        RG_HI   = 2'd2,
        RG_MISC = 2'd3
    } reg_region_e;

    typedef enum logic [2:0] {
        MX_ENABLE = 3'd0,
        MX_AMATCH = 3'd1,
        MX_AMASK  = 3'd2,
        MX_VMATCH = 3'd3,
        MX_VMASK  = 3'd4
    } misc_sel_e;

    // enable register layout: [3:0] code arm 1..4, [4] data arm, [5] reads, [6] writes
    typedef struct packed {
        logic                on_wr;
        logic                on_rd;
        logic                data_en;
        logic [NUM_CODE-2:0] code_en;
    } arm_t;

    typedef struct packed {
        logic [DW-1:0] match;
        logic [DW-1:0] mask;
    } mcmp_t;

    typedef struct packed {
        arm_t  arm;
        mcmp_t addr;
        mcmp_t value;
    } dbp_cfg_t;

    localparam int ARM_W = $bits(arm_t);
    localparam logic [PC_W-1:0] CODE_RST = '1;

    function automatic logic masked_eq(input logic [DW-1:0] obs, input mcmp_t c);
        return ((obs ^ c.match) & ~c.mask) == '0;
    endfunction

    function automatic reg_region_e region_of(input logic [RA_W-1:0] a);
        return reg_region_e'(a[RA_W-1 -: 2]);
    endfunction

    function automatic logic [IDX_W-1:0] index_of(input logic [RA_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [RA_W-1:0]                addr,
    input  logic [PC_W-1:0]                wdata,
    output logic [NUM_CODE-1:0][PC_W-1:0]  code_addr_o,
    output dbp_cfg_t                       dcfg_o
);

    reg_region_e           region;
    logic [IDX_W-1:0]      idx;
    dbp_cfg_t              dcfg_q;

    assign region = region_of(addr);
    assign idx    = index_of(addr);

    for (genvar k = 0; k < NUM_CODE; k++) begin : g_code
        logic [PC_W-1:0] q;
        logic            sel;

        assign sel = we && (idx == IDX_W'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= CODE_RST;
            end else if (sel) begin
                case (region)
                    RG_FULL: q              <= wdata;
                    RG_LO:   q[DW-1:0]      <= wdata[DW-1:0];
                    RG_HI:   q[PC_W-1:DW]   <= wdata[HI_W-1:0];
                    default: ;
                endcase
            end
        end

        assign code_addr_o[k] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dcfg_q.arm         <= '0;
            dcfg_q.addr.match  <= '0;
            dcfg_q.addr.mask   <= '1;
            dcfg_q.value.match <= '0;
            dcfg_q.value.mask  <= '1;
        end else if (we && region == RG_MISC) begin
            case (misc_sel_e'(idx))
                MX_ENABLE: dcfg_q.arm         <= arm_t'(wdata[ARM_W-1:0]);
                MX_AMATCH: dcfg_q.addr.match  <= wdata[DW-1:0];
                MX_AMASK:  dcfg_q.addr.mask   <= wdata[DW-1:0];
                MX_VMATCH: dcfg_q.value.match <= wdata[DW-1:0];
                MX_VMASK:  dcfg_q.value.mask  <= wdata[DW-1:0];
                default: ;
            endcase
        end
    end

    assign dcfg_o = dcfg_q;

endmodule

// File: rtl/bkpt_code_cmp.sv
module bkpt_code_cmp
    import bkpt_pkg::*;
(
    input  logic                           pc_valid,
    input  logic [PC_W-1:0]                pc,
    input  logic [NUM_CODE-1:0][PC_W-1:0]  code_addr,
    input  logic [NUM_CODE-2:0]            code_en,
    output logic                           code_hit
);

    logic [NUM_CODE-1:0] armed;
    logic [NUM_CODE-1:0] eq;

    for (genvar k = 0; k < NUM_CODE; k++) begin : g_cmp
        if (k == 0) begin : g_fixed
            assign armed[k] = 1'b1;
        end else begin : g_gated
            assign armed[k] = code_en[k-1];
        end
        assign eq[k] = (pc == code_addr[k]);
    end

    assign code_hit = pc_valid && |(eq & armed);

endmodule

// File: rtl/bkpt_data_cmp.sv
module bkpt_data_cmp
    import bkpt_pkg::*;
(
    input  logic          dacc_valid,
    input  logic          dacc_write,
    input  logic [DW-1:0] dacc_addr,
    input  logic [DW-1:0] dacc_data,
    input  dbp_cfg_t      cfg,
    output logic          data_hit
);

    logic type_ok;
    logic addr_ok;
    logic value_ok;

    assign type_ok  = dacc_write ? cfg.arm.on_wr : cfg.arm.on_rd;
    assign addr_ok  = masked_eq(dacc_addr, cfg.addr);
    assign value_ok = masked_eq(dacc_data, cfg.value);
    assign data_hit = dacc_valid && cfg.arm.data_en && type_ok && addr_ok && value_ok;

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [PC_W-1:0] reg_wdata,
    input  logic            pc_valid,
    input  logic [PC_W-1:0] pc,
    input  logic            dacc_valid,
    input  logic            dacc_write,
    input  logic [DW-1:0]   dacc_addr,
    input  logic [DW-1:0]   dacc_data,
    input  logic            stop_cmd,
    output logic            brk_req,
    output logic            brk_status
);

    logic [NUM_CODE-1:0][PC_W-1:0] code_addr_w;
    dbp_cfg_t                      dcfg_w;
    logic                          code_hit;
    logic                          data_hit;
    logic                          any_hit;
    logic [PC_W-1:0]               bp0_addr_w;
    logic                          data_en_w;

    bkpt_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .we          (reg_we),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .code_addr_o (code_addr_w),
        .dcfg_o      (dcfg_w)
    );

    bkpt_code_cmp u_code (
        .pc_valid  (pc_valid),
        .pc        (pc),
        .code_addr (code_addr_w),
        .code_en   (dcfg_w.arm.code_en),
        .code_hit  (code_hit)
    );

    bkpt_data_cmp u_data (
        .dacc_valid (dacc_valid),
        .dacc_write (dacc_write),
        .dacc_addr  (dacc_addr),
        .dacc_data  (dacc_data),
        .cfg        (dcfg_w),
        .data_hit   (data_hit)
    );

    assign any_hit    = code_hit || data_hit;
    assign bp0_addr_w = code_addr_w[0];
    assign data_en_w  = dcfg_w.arm.data_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_req    <= 1'b0;
            brk_status <= 1'b0;
        end else begin
            brk_req    <= any_hit;
            brk_status <= any_hit || (brk_status && !stop_cmd);
        end
    end

endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk
    import bkpt_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            pc_valid,
    input logic [PC_W-1:0] pc,
    input logic            dacc_valid,
    input logic            stop_cmd,
    input logic            brk_req,
    input logic            brk_status,
    input logic [PC_W-1:0] bp0_addr,
    input logic            data_en
);

    logic started;
    logic bp0_eq;

    always_ff @(posedge clk) begin
        if (rst) started <= 1'b0;
        else     started <= 1'b1;
    end

    assign bp0_eq = pc_valid && (pc == bp0_addr);

    AST_REQ_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> brk_status);                                              // R10

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        started && $past(brk_status) && !$past(stop_cmd) |-> brk_status);     // R10

    AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        started && $past(stop_cmd) && !brk_req |-> !brk_status);              // R10

    AST_IDLE_NO_BREAK: assert property (@(posedge clk) disable iff (rst)
        started && !$past(pc_valid) && !$past(dacc_valid) |-> !brk_req);      // R5

    AST_BP0_ALWAYS_ARMED: assert property (@(posedge clk) disable iff (rst)
        started && $past(bp0_eq) |-> brk_req);                                // R3

    AST_DATA_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        started && !$past(pc_valid) && !$past(data_en) |-> !brk_req);         // R9

endmodule

bind bkpt_unit bkpt_unit_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .pc_valid   (pc_valid),
    .pc         (pc),
    .dacc_valid (dacc_valid),
    .stop_cmd   (stop_cmd),
    .brk_req    (brk_req),
    .brk_status (brk_status),
    .bp0_addr   (bp0_addr_w),
    .data_en    (data_en_w)
);

// File: tb/bkpt_unit_tb_top.sv
module bkpt_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic        pc_valid = 1'b0;
    logic [23:0] pc = '0;
    logic        dacc_valid = 1'b0;
    logic        dacc_write = 1'b0;
    logic [15:0] dacc_addr = '0;
    logic [15:0] dacc_data = '0;
    logic        stop_cmd = 1'b0;
    logic        brk_req;
    logic        brk_status;

    always #4 clk = ~clk;

    bkpt_unit dut_i (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .pc_valid   (pc_valid),
        .pc         (pc),
        .dacc_valid (dacc_valid),
        .dacc_write (dacc_write),
        .dacc_addr  (dacc_addr),
        .dacc_data  (dacc_data),
        .stop_cmd   (stop_cmd),
        .brk_req    (brk_req),
        .brk_status (brk_status)
    );

    typedef struct {
        logic  req;
        logic  stat;
        string rq;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    logic exp_stat = 1'b0;
    bit   done     = 1'b0;

    // register addresses
    localparam logic [4:0] A_EN = 5'd24, A_AM = 5'd25, A_AK = 5'd26, A_VM = 5'd27, A_VK = 5'd28;

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected outputs
    task automatic drive(input logic we, input logic [4:0] a, input logic [23:0] d,
                         input logic pv, input logic [23:0] p,
                         input logic dv, input logic dw, input logic [15:0] da, input logic [15:0] dd,
                         input logic stp, input logic hit, input string rq);
        exp_t e;
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d;
        pc_valid = pv; pc = p;
        dacc_valid = dv; dacc_write = dw; dacc_addr = da; dacc_data = dd;
        stop_cmd = stp;
        exp_stat = hit | (exp_stat & ~stp);
        e.req = hit; e.stat = exp_stat; e.rq = rq;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [4:0] a, input logic [23:0] d, input string rq);
        drive(1'b1, a, d, 1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, rq);
    endtask

    task automatic fetch(input logic [23:0] p, input logic hit, input string rq);
        drive(1'b0, '0, '0, 1'b1, p, 1'b0, 1'b0, '0, '0, 1'b0, hit, rq);
    endtask

    task automatic dacc(input logic w, input logic [15:0] da, input logic [15:0] dd,
                        input logic hit, input string rq);
        drive(1'b0, '0, '0, 1'b0, '0, 1'b1, w, da, dd, 1'b0, hit, rq);
    endtask

    task automatic idle(input logic stp, input string rq);
        drive(1'b0, '0, '0, 1'b0, '0, 1'b0, 1'b0, '0, '0, stp, 1'b0, rq);
    endtask

    // monitor: compares each queued item just after the edge that produces it
    always @(posedge clk) begin
        #2;
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (brk_req !== e.req || brk_status !== e.stat) begin
                n_fail++;
                $display("FAIL %s: req/status actual %b/%b expected %b/%b",
                         e.rq, brk_req, brk_status, e.req, e.stat);
            end
        end
    end

    initial begin
        #(8 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (brk_req !== 1'b0 || brk_status !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: actual %b/%b expected 0/0", brk_req, brk_status);
        end
        rst = 1'b0;

        // R1: comparator 0 resets to all ones, so address 0 is not a break
        fetch(24'h000000, 1'b0, "R1 bp0 reset not zero");
        fetch(24'hFFFFFF, 1'b1, "R1 bp0 reset value");
        idle(1'b0, "R11 one-cycle pulse");
        idle(1'b1, "R10 stop clears");
        idle(1'b0, "R10 cleared stays clear");

        // R2: full write to comparator 0
        wr(5'd0, 24'h001234, "R4 full write");
        fetch(24'h001234, 1'b1, "R2 code match");
        fetch(24'h001235, 1'b0, "R2 code mismatch");
        fetch(24'h001234, 1'b1, "R11 back-to-back 1");
        fetch(24'h001234, 1'b1, "R11 back-to-back 2");

        // R3: comparators 1..4 gated by enable bits
        wr(5'd1, 24'h00ABCD, "R4 full write bp1");
        fetch(24'h00ABCD, 1'b0, "R3 bp1 disarmed");
        wr(A_EN, 24'h000001, "R3 arm bp1");
        fetch(24'h00ABCD, 1'b1, "R3 bp1 armed");
        wr(5'd4, 24'h777777, "R4 full write bp4");
        fetch(24'h777777, 1'b0, "R3 bp4 disarmed");
        wr(A_EN, 24'h000009, "R3 arm bp4");
        fetch(24'h777777, 1'b1, "R3 bp4 armed");

        // R4: split write of comparator 2
        wr(A_EN, 24'h00000B, "R3 arm bp2");
        wr(5'd10, 24'h005678, "R4 low part");
        fetch(24'hFF5678, 1'b1, "R4 low part kept high reset");
        wr(5'd18, 24'h00009A, "R4 high part");
        fetch(24'h9A5678, 1'b1, "R4 composed address");
        fetch(24'hFF5678, 1'b0, "R4 old address gone");

        // R5: fetch not valid
        drive(1'b0, '0, '0, 1'b0, 24'h9A5678, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, "R5 no fetch valid");

        // R12: write and fetch in one cycle
        drive(1'b1, 5'd2, 24'h111111, 1'b1, 24'h9A5678, 1'b0, 1'b0, '0, '0, 1'b0, 1'b1, "R12 old value used");
        fetch(24'h9A5678, 1'b0, "R12 new value active");
        fetch(24'h111111, 1'b1, "R12 new value hit");
        idle(1'b1, "R10 stop clears");

        // data comparator setup
        wr(A_AM, 24'h004000, "R4 addr match");
        wr(A_AK, 24'h0000FF, "R4 addr mask");
        wr(A_VM, 24'h001234, "R4 value match");
        wr(A_VK, 24'h000000, "R4 value mask");
        wr(A_EN, 24'h000060, "R9 data disarmed");
        dacc(1'b0, 16'h4012, 16'h1234, 1'b0, "R9 data disabled");
        wr(A_EN, 24'h000070, "R9 data armed");
        dacc(1'b0, 16'h4012, 16'h1234, 1'b1, "R6 ignored bits differ");
        dacc(1'b0, 16'h4112, 16'h1234, 1'b0, "R6 compared bit differs");
        dacc(1'b0, 16'h40FF, 16'h1235, 1'b0, "R7 value mismatch");
        dacc(1'b1, 16'h4000, 16'h1234, 1'b1, "R8 write with both");

        // R8: access type selection
        wr(A_EN, 24'h000030, "R8 reads only");
        dacc(1'b1, 16'h4000, 16'h1234, 1'b0, "R8 write ignored");
        dacc(1'b0, 16'h4000, 16'h1234, 1'b1, "R8 read hits");
        wr(A_EN, 24'h000050, "R8 writes only");
        dacc(1'b0, 16'h4000, 16'h1234, 1'b0, "R8 read ignored");
        dacc(1'b1, 16'h4000, 16'h1234, 1'b1, "R8 write hits");

        // R10: set wins over stop in the same cycle
        drive(1'b0, '0, '0, 1'b0, '0, 1'b1, 1'b1, 16'h4000, 16'h1234, 1'b1, 1'b1, "R10 set beats stop");
        idle(1'b0, "R10 sticky");
        idle(1'b1, "R10 stop clears");

        // code and data hit together give one request
        drive(1'b0, '0, '0, 1'b1, 24'h001234, 1'b1, 1'b1, 16'h4000, 16'h1234, 1'b0, 1'b1, "R2 code and data together");
        idle(1'b0, "R11 pulse ends");
        idle(1'b0, "R5 idle");

        repeat (3) @(negedge clk);
        report();
    end

endmodule